// File: doc/BRIEF.md
# UART Flow Controller

This block makes the flow-control decisions for one UART channel. On the receive side it watches the receive FIFO fill level against two programmable marks. It drops its ready-to-receive output when the level climbs to the upper mark and raises it again once the level has drained to the lower mark. In software flow mode the same crossings instead ask the transmitter to insert a stop or go character. On the transmit side it combines the far end's clear-to-send line with any stop/go characters received, and produces one permit signal. The transmitter samples that signal before it starts each word.

Received characters pass through the block on their way to the receive FIFO. In software flow mode, characters that match the programmed stop or go codes are used up here and are not forwarded. With software flow off, the stop code can still be watched for as a plain special character. FIFO storage, shift registers and baud timing belong to neighbouring blocks.

Top module: `fc_flow_ctrl`

## Requirements
- R1: After reset, rtsReady and txPermit are 1, and rxWriteEn, sendXon, sendXoff and specialHit are 0.
- R2: Each mark is its 4-bit code times eight. With autoRtsEn high, rtsReady goes to 0 one cycle after rxLevel is greater than or equal to haltCode*8, and stays 1 while rxLevel is below that value.
- R3: Once dropped, rtsReady stays 0 while rxLevel is above resumeCode*8. It returns to 1 one cycle after rxLevel is less than or equal to resumeCode*8. If both conditions hold at once, the halt condition wins.
- R4: With autoRtsEn low, rtsReady is 1 whatever the fill level.
- R5: With autoCtsEn high, ctsIn is taken into txPermit only in cycles where txBusy is 0. ctsIn at 1 gives txPermit 0 one cycle later. While txBusy is 1, txPermit does not follow ctsIn. With autoCtsEn low, ctsIn has no effect.
- R6: With swFlowEn high, a received character equal to xoffChar sets txPermit to 0 one cycle later, and one equal to xonChar sets it back to 1. If the two codes are equal, the stop action wins.
- R7: rxWriteEn pulses for one cycle, with rxWriteData holding the character, one cycle after each rxCharValid. The exception is a character that matches xonChar or xoffChar while swFlowEn is high: that character is not forwarded.
- R8: With swFlowEn high, sendXoff pulses for exactly one cycle when the halt condition of R2 begins, and sendXon pulses for exactly one cycle when the release of R3 happens. The two never pulse together.
- R9: With swFlowEn low and specialDetEn high, a received character equal to xoffChar gives a one-cycle specialHit pulse one cycle later. The character is still forwarded, and txPermit is not changed by xonChar or xoffChar.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| autoRtsEn | input | 1 | Drive rtsReady from the fill level |
| autoCtsEn | input | 1 | Gate transmission with ctsIn |
| swFlowEn | input | 1 | Enable stop/go character flow control |
| specialDetEn | input | 1 | Detect xoffChar as a special character when swFlowEn is low |
| haltCode | input | 4 | Upper mark code, mark = code*8 |
| resumeCode | input | 4 | Lower mark code, mark = code*8 |
| rxLevel | input | 8 | Current receive FIFO fill level |
| ctsIn | input | 1 | Far end clear-to-send, 1 = stop |
| txBusy | input | 1 | Transmitter is shifting a word |
| rxCharValid | input | 1 | Received character strobe |
| rxChar | input | 8 | Received character |
| xonChar | input | 8 | Go character code |
| xoffChar | input | 8 | Stop character code |
| rtsReady | output | 1 | 1 = ready to receive |
| txPermit | output | 1 | Transmitter may start a new word |
| rxWriteEn | output | 1 | Receive FIFO write strobe |
| rxWriteData | output | 8 | Character to write into the receive FIFO |
| sendXon | output | 1 | Request to inject the go character |
| sendXoff | output | 1 | Request to inject the stop character |
| specialHit | output | 1 | Special character seen |

## Verification
Every result comes from a single register stage. A level, CTS or character presented before a clock edge shows up on the outputs just after that edge, one cycle later. The one exception is rtsReady, which also follows autoRtsEn directly in the same cycle. The driver applies each stimulus at the falling edge and queues the output values due after the next rising edge. The monitor checks them one nanosecond after that rising edge. For pulse outputs, the next queued item expects 0, which shows that each pulse lasts exactly one cycle.

// File: rtl/fc_pkg.sv
package fc_pkg;
  // decisions handed from the compare logic to the state registers
  typedef struct packed {
    logic reachHalt;   // level at or above the upper mark
    logic atResume;    // level at or below the lower mark
    logic xonHit;      // go character received under software flow
    logic xoffHit;     // stop character received under software flow
    logic specHit;     // stop code seen as a special character
    logic passChar;    // character goes on to the receive FIFO
  } fcStrobes_t;
endpackage

// File: rtl/fc_match.sv
module fc_match
  import fc_pkg::*;
#(
  parameter int unsigned LEVEL_W     = 8,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned SCALE_SHIFT = 3
) (
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic [CODE_W-1:0]  haltCode,
  input  logic [CODE_W-1:0]  resumeCode,
  input  logic               swFlowEn,
  input  logic               specialDetEn,
  input  logic               rxCharValid,
  input  logic [CHAR_W-1:0]  rxChar,
  input  logic [CHAR_W-1:0]  xonChar,
  input  logic [CHAR_W-1:0]  xoffChar,
  output fcStrobes_t         strobes
);
  logic [LEVEL_W-1:0] haltMark;
  logic [LEVEL_W-1:0] resumeMark;
  logic               isXon;
  logic               isXoff;

  always_comb begin
    haltMark   = LEVEL_W'(haltCode) << SCALE_SHIFT;
    resumeMark = LEVEL_W'(resumeCode) << SCALE_SHIFT;
    isXoff     = rxCharValid && (rxChar == xoffChar);
    isXon      = rxCharValid && (rxChar == xonChar);

    strobes.reachHalt = (rxLevel >= haltMark);
    strobes.atResume  = (rxLevel <= resumeMark);
    strobes.xoffHit   = swFlowEn && isXoff;
    strobes.xonHit    = swFlowEn && isXon && !isXoff;
    strobes.specHit   = !swFlowEn && specialDetEn && isXoff;
    strobes.passChar  = rxCharValid && !(swFlowEn && (isXon || isXoff));
  end
endmodule

// File: rtl/fc_state.sv
module fc_state
  import fc_pkg::*;
#(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fcStrobes_t        strobes,
  input  logic              autoRtsEn,
  input  logic              autoCtsEn,
  input  logic              swFlowEn,
  input  logic              ctsIn,
  input  logic              txBusy,
  input  logic [CHAR_W-1:0] rxChar,
  output logic              rtsReady,
  output logic              txPermit,
  output logic              rxWriteEn,
  output logic [CHAR_W-1:0] rxWriteData,
  output logic              sendXon,
  output logic              sendXoff,
  output logic              specialHit
);
  logic rxHalted;
  logic nextHalted;
  logic swGate;
  logic ctsGate;

  // hysteresis: the halt condition wins over release
  always_comb begin
    if (strobes.reachHalt)     nextHalted = 1'b1;
    else if (strobes.atResume) nextHalted = 1'b0;
    else                       nextHalted = rxHalted;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxHalted    <= 1'b0;
      swGate      <= 1'b1;
      ctsGate     <= 1'b1;
      rxWriteEn   <= 1'b0;
      rxWriteData <= '0;
      sendXon     <= 1'b0;
      sendXoff    <= 1'b0;
      specialHit  <= 1'b0;
    end else begin
      rxHalted <= nextHalted;
      sendXoff <= swFlowEn && !rxHalted && nextHalted;
      sendXon  <= swFlowEn && rxHalted && !nextHalted;

      if (!swFlowEn)            swGate <= 1'b1;
      else if (strobes.xoffHit) swGate <= 1'b0;
      else if (strobes.xonHit)  swGate <= 1'b1;

      // CTS is only taken at a word boundary
      if (!autoCtsEn)   ctsGate <= 1'b1;
      else if (!txBusy) ctsGate <= !ctsIn;

      rxWriteEn  <= strobes.passChar;
      specialHit <= strobes.specHit;
      if (strobes.passChar) rxWriteData <= rxChar;
    end
  end

  assign rtsReady = !(autoRtsEn && rxHalted);
  assign txPermit = swGate && ctsGate;
endmodule

// File: rtl/fc_flow_ctrl.sv
module fc_flow_ctrl
  import fc_pkg::*;
#(
  parameter int unsigned LEVEL_W     = 8,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned SCALE_SHIFT = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               autoRtsEn,
  input  logic               autoCtsEn,
  input  logic               swFlowEn,
  input  logic               specialDetEn,
  input  logic [CODE_W-1:0]  haltCode,
  input  logic [CODE_W-1:0]  resumeCode,
  input  logic [LEVEL_W-1:0] rxLevel,
  input  logic               ctsIn,
  input  logic               txBusy,
  input  logic               rxCharValid,
  input  logic [CHAR_W-1:0]  rxChar,
  input  logic [CHAR_W-1:0]  xonChar,
  input  logic [CHAR_W-1:0]  xoffChar,
  output logic               rtsReady,
  output logic               txPermit,
  output logic               rxWriteEn,
  output logic [CHAR_W-1:0]  rxWriteData,
  output logic               sendXon,
  output logic               sendXoff,
  output logic               specialHit
);
  fcStrobes_t strobes;

  fc_match #(
    .LEVEL_W(LEVEL_W), .CODE_W(CODE_W), .CHAR_W(CHAR_W), .SCALE_SHIFT(SCALE_SHIFT)
  ) u_match (
    .rxLevel(rxLevel), .haltCode(haltCode), .resumeCode(resumeCode),
    .swFlowEn(swFlowEn), .specialDetEn(specialDetEn), .rxCharValid(rxCharValid),
    .rxChar(rxChar), .xonChar(xonChar), .xoffChar(xoffChar), .strobes(strobes)
  );

  fc_state #(.CHAR_W(CHAR_W)) u_state (
    .clk(clk), .rstN(rstN), .strobes(strobes), .autoRtsEn(autoRtsEn),
    .autoCtsEn(autoCtsEn), .swFlowEn(swFlowEn), .ctsIn(ctsIn), .txBusy(txBusy),
    .rxChar(rxChar), .rtsReady(rtsReady), .txPermit(txPermit),
    .rxWriteEn(rxWriteEn), .rxWriteData(rxWriteData), .sendXon(sendXon),
    .sendXoff(sendXoff), .specialHit(specialHit)
  );
endmodule

// File: rtl/fc_flow_ctrl_chk.sv
module fc_flow_ctrl_chk #(
  parameter int unsigned LEVEL_W     = 8,
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned CHAR_W      = 8,
  parameter int unsigned SCALE_SHIFT = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               autoRtsEn,
  input logic               autoCtsEn,
  input logic               swFlowEn,
  input logic               specialDetEn,
  input logic [CODE_W-1:0]  haltCode,
  input logic [LEVEL_W-1:0] rxLevel,
  input logic               txBusy,
  input logic               rxCharValid,
  input logic [CHAR_W-1:0]  rxChar,
  input logic [CHAR_W-1:0]  xonChar,
  input logic [CHAR_W-1:0]  xoffChar,
  input logic               rtsReady,
  input logic               txPermit,
  input logic               rxWriteEn,
  input logic               sendXon,
  input logic               sendXoff,
  input logic               specialHit
);
  logic [LEVEL_W-1:0] upperMark;
  assign upperMark = LEVEL_W'(haltCode) << SCALE_SHIFT;

  p_halt_drops_rts_r2: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && rxLevel >= upperMark) |=> (!rtsReady || !autoRtsEn));

  p_rts_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |-> rtsReady);

  p_cts_word_boundary_r5: assert property (@(posedge clk) disable iff (!rstN)
    (autoCtsEn && !swFlowEn && txBusy) |=> $stable(txPermit));

  p_xoff_stops_tx_r6: assert property (@(posedge clk) disable iff (!rstN)
    (rxCharValid && swFlowEn && rxChar == xoffChar) |=> !txPermit);

  p_flow_char_dropped_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rxCharValid && swFlowEn && (rxChar == xoffChar || rxChar == xonChar)) |=> !rxWriteEn);

  p_no_dual_request_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(sendXon && sendXoff));

  p_special_seen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rxCharValid && !swFlowEn && specialDetEn && rxChar == xoffChar) |=> (specialHit && rxWriteEn));
endmodule

bind fc_flow_ctrl fc_flow_ctrl_chk #(
  .LEVEL_W(LEVEL_W), .CODE_W(CODE_W), .CHAR_W(CHAR_W), .SCALE_SHIFT(SCALE_SHIFT)
) u_chk (
  .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
  .swFlowEn(swFlowEn), .specialDetEn(specialDetEn), .haltCode(haltCode),
  .rxLevel(rxLevel), .txBusy(txBusy), .rxCharValid(rxCharValid), .rxChar(rxChar),
  .xonChar(xonChar), .xoffChar(xoffChar), .rtsReady(rtsReady), .txPermit(txPermit),
  .rxWriteEn(rxWriteEn), .sendXon(sendXon), .sendXoff(sendXoff), .specialHit(specialHit)
);

// File: tb/fc_flow_ctrl_test.sv
`timescale 1ns/1ps
module fc_flow_ctrl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoRtsEn = 0, autoCtsEn = 0, swFlowEn = 0, specialDetEn = 0;
  logic [3:0] haltCode = 4'd5, resumeCode = 4'd2;   // marks 40 and 16
  logic [7:0] rxLevel = 0;
  logic ctsIn = 0, txBusy = 0, rxCharValid = 0;
  logic [7:0] rxChar = 0, xonChar = 8'h11, xoffChar = 8'h13;
  logic rtsReady, txPermit, rxWriteEn, sendXon, sendXoff, specialHit;
  logic [7:0] rxWriteData;

  int vecCnt = 0;
  int failCnt = 0;
  bit done = 0;

  typedef struct {
    logic rts; logic permit; logic wr; logic [7:0] data;
    logic xon; logic xoff; logic spec; string tag;
  } expItem_t;
  expItem_t expQ[$];

  always #10 clk = ~clk;   // 50 MHz

  fc_flow_ctrl uut (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
    .swFlowEn(swFlowEn), .specialDetEn(specialDetEn), .haltCode(haltCode),
    .resumeCode(resumeCode), .rxLevel(rxLevel), .ctsIn(ctsIn), .txBusy(txBusy),
    .rxCharValid(rxCharValid), .rxChar(rxChar), .xonChar(xonChar), .xoffChar(xoffChar),
    .rtsReady(rtsReady), .txPermit(txPermit), .rxWriteEn(rxWriteEn),
    .rxWriteData(rxWriteData), .sendXon(sendXon), .sendXoff(sendXoff),
    .specialHit(specialHit)
  );

  // driver: queue what is due after the next rising edge, then move on
  task automatic step(input logic rts, input logic permit, input logic wr,
                      input logic [7:0] data, input logic xon, input logic xoff,
                      input logic spec, input string tag);
    expItem_t it;
    it.rts = rts; it.permit = permit; it.wr = wr; it.data = data;
    it.xon = xon; it.xoff = xoff; it.spec = spec; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      vecCnt++;
      if (rtsReady !== e.rts || txPermit !== e.permit || rxWriteEn !== e.wr ||
          (e.wr && rxWriteData !== e.data) || sendXon !== e.xon ||
          sendXoff !== e.xoff || specialHit !== e.spec) begin
        failCnt++;
        $display("FAIL %s: got rts=%b permit=%b wr=%b data=%h xon=%b xoff=%b spec=%b, expected rts=%b permit=%b wr=%b data=%h xon=%b xoff=%b spec=%b",
                 e.tag, rtsReady, txPermit, rxWriteEn, rxWriteData, sendXon, sendXoff,
                 specialHit, e.rts, e.permit, e.wr, e.data, e.xon, e.xoff, e.spec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    vecCnt++;
    if (rtsReady !== 1'b1 || txPermit !== 1'b1 || rxWriteEn !== 1'b0 ||
        sendXon !== 1'b0 || sendXoff !== 1'b0 || specialHit !== 1'b0) begin
      failCnt++;
      $display("FAIL R1: got rts=%b permit=%b wr=%b xon=%b xoff=%b spec=%b, expected 1 1 0 0 0 0",
               rtsReady, txPermit, rxWriteEn, sendXon, sendXoff, specialHit);
    end
    rstN = 1'b1;
    @(negedge clk);

    // R4 level ignored without auto RTS
    rxLevel = 8'd100; step(1, 1, 0, 0, 0, 0, 0, "R4");
    rxLevel = 8'd0;   step(1, 1, 0, 0, 0, 0, 0, "R4");

    // R2 / R3 marks and hysteresis
    autoRtsEn = 1;
    rxLevel = 8'd39; step(1, 1, 0, 0, 0, 0, 0, "R2 below mark");
    rxLevel = 8'd40; step(0, 1, 0, 0, 0, 0, 0, "R2 at mark");
    rxLevel = 8'd20; step(0, 1, 0, 0, 0, 0, 0, "R3 above resume");
    rxLevel = 8'd17; step(0, 1, 0, 0, 0, 0, 0, "R3 above resume");
    rxLevel = 8'd16; step(1, 1, 0, 0, 0, 0, 0, "R3 at resume");
    rxLevel = 8'd0;  step(1, 1, 0, 0, 0, 0, 0, "R3");
    // R3 overlapping marks: halt wins
    haltCode = 4'd1; resumeCode = 4'd3; rxLevel = 8'd10;
    step(0, 1, 0, 0, 0, 0, 0, "R3 halt priority");
    haltCode = 4'd5; resumeCode = 4'd2; rxLevel = 8'd0;
    step(1, 1, 0, 0, 0, 0, 0, "R3");

    // R8 requests in software mode
    swFlowEn = 1;
    rxLevel = 8'd40; step(0, 1, 0, 0, 0, 1, 0, "R8 xoff request");
    step(0, 1, 0, 0, 0, 0, 0, "R8 single pulse");
    rxLevel = 8'd16; step(1, 1, 0, 0, 1, 0, 0, "R8 xon request");
    rxLevel = 8'd0;  step(1, 1, 0, 0, 0, 0, 0, "R8 single pulse");

    // R6 / R7 stop/go characters
    rxCharValid = 1; rxChar = 8'h13; step(1, 0, 0, 0, 0, 0, 0, "R6 xoff");
    rxChar = 8'h41;                  step(1, 0, 1, 8'h41, 0, 0, 0, "R7 forwarded");
    rxCharValid = 0;                 step(1, 0, 0, 0, 0, 0, 0, "R7 idle");
    rxCharValid = 1; rxChar = 8'h11; step(1, 1, 0, 0, 0, 0, 0, "R6 xon");
    rxCharValid = 0;                 step(1, 1, 0, 0, 0, 0, 0, "R7 idle");
    // R6 equal codes: stop wins
    xonChar = 8'h13;
    rxCharValid = 1; rxChar = 8'h13; step(1, 0, 0, 0, 0, 0, 0, "R6 equal codes");
    xonChar = 8'h11; rxChar = 8'h11; step(1, 1, 0, 0, 0, 0, 0, "R6 xon");
    rxCharValid = 0;                 step(1, 1, 0, 0, 0, 0, 0, "R6");

    // R9 special detection with software flow off
    swFlowEn = 0; specialDetEn = 1;
    rxCharValid = 1; rxChar = 8'h13; step(1, 1, 1, 8'h13, 0, 0, 1, "R9 special");
    rxChar = 8'h11;                  step(1, 1, 1, 8'h11, 0, 0, 0, "R9 no gating");
    rxCharValid = 0;                 step(1, 1, 0, 0, 0, 0, 0, "R9");

    // R5 CTS at word boundaries
    autoCtsEn = 1;
    ctsIn = 1;             step(1, 0, 0, 0, 0, 0, 0, "R5 idle stop");
    ctsIn = 0;             step(1, 1, 0, 0, 0, 0, 0, "R5 idle go");
    txBusy = 1; ctsIn = 1; step(1, 1, 0, 0, 0, 0, 0, "R5 busy word");
    step(1, 1, 0, 0, 0, 0, 0, "R5 busy word");
    txBusy = 0;            step(1, 0, 0, 0, 0, 0, 0, "R5 boundary");
    ctsIn = 0;             step(1, 1, 0, 0, 0, 0, 0, "R5 resume");
    autoCtsEn = 0; ctsIn = 1; step(1, 1, 0, 0, 0, 0, 0, "R5 disabled");

    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
    $finish;
  end
endmodule